// File: doc/BRIEF.md
# Clear-on-Compare 16-bit Timer Core

This block is a 16-bit up-counter that advances by one on each cycle in which its one-cycle count-enable tick is high. A four-bit waveform mode chooses how the count ends a period: free running with an overflow flag at the all-ones value, or cleared back to zero when the count meets a TOP value. TOP is taken either from compare register A or from the capture register. Three compare channels (A, B, C) raise flags when the count meets their registers. Flags are held in a status vector, cleared by write-one, and each source drives its own interrupt output through a mask.

Software may load the count directly. The first tick after a load advances the count but has no compare or TOP match, so loading a value equal to a compare or TOP value does not raise that event. A power-reduction input holds the timer in reset while it is high.

Top module: `ctc_timer16`

## Requirements
- R1: The mode is {ctlB[4:3], ctlA[1:0]}. Value 0 is free running, 4 clears at compare A, 12 clears at the capture register, and every other value behaves as 0.
- R2: On a cycle with tick high, no load and no power hold, the count advances by one or clears. With tick low it holds.
- R3: In every mode, a tick at the all-ones count gives 0 and sets flag bit 0 (overflow).
- R4: In mode 4, a tick at a count equal to cmpA gives 0 and sets flag bit 1. The count never passes cmpA from below.
- R5: In mode 12, a tick at a count equal to topIcr gives 0 and sets flag bit 5 (capture).
- R6: In any mode, a tick at a count equal to cmpA, cmpB or cmpC sets flag bit 1, 2 or 3.
- R7: loadEn writes loadVal into the count on the next edge and has priority over tick. The first tick after a load sets no compare flag, no capture flag and does no TOP clear.
- R8: Flags set whether masked or not. irqOvf, irqCmpA, irqCmpB, irqCmpC and irqCapt equal flag bits 0, 1, 2, 3, 5 ANDed with the same bits of intMask.
- R9: With flagClrEn high, each 1 in flagClrVal clears that flag bit and each 0 leaves it. A set in the same cycle wins over the clear.
- R10: While pwrHold is high, every interrupt output is low at once, and on the next edge the count and all flags are zero.
- R11: Flag bits 4, 6 and 7 always read 0.
- R12: After rst_n low the count and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrHold | input | 1 | Power-reduction hold, holds the timer in reset |
| tick | input | 1 | Count-enable pulse |
| ctlA | input | 8 | Control A, bits 1:0 are mode bits 1:0 |
| ctlB | input | 8 | Control B, bits 4:3 are mode bits 3:2 |
| cmpA | input | WIDTH | Compare A value and TOP in mode 4 |
| cmpB | input | WIDTH | Compare B value |
| cmpC | input | WIDTH | Compare C value |
| topIcr | input | WIDTH | Capture register, TOP in mode 12 |
| loadEn | input | 1 | Count load strobe |
| loadVal | input | WIDTH | Count load value |
| intMask | input | 8 | Interrupt mask, same bit positions as flags |
| flagClrEn | input | 1 | Flag clear strobe |
| flagClrVal | input | 8 | Write-one-to-clear pattern |
| count | output | WIDTH | Current count |
| flags | output | 8 | Flag vector |
| irqOvf | output | 1 | Overflow interrupt |
| irqCmpA | output | 1 | Compare A interrupt |
| irqCmpB | output | 1 | Compare B interrupt |
| irqCmpC | output | 1 | Compare C interrupt |
| irqCapt | output | 1 | Capture-as-TOP interrupt |

## Verification
The bench builds the block with WIDTH set to 8. This puts the all-ones wrap only 256 ticks away, so overflow appears many times in a few thousand cycles. The same narrow width means random compare, TOP and load values often coincide with the count. That makes loads onto a match value, set-versus-clear collisions and overflow-with-TOP cases frequent. The counter logic does not depend on the width, so the default build uses the same paths.

// File: rtl/ctc_timer16_pkg.sv
package ctc_timer16_pkg;
  localparam int NCH = 3;            // compare channels A, B, C
  localparam int FLG_OVF = 0;
  localparam int FLG_CMP0 = 1;       // A=1, B=2, C=3
  localparam int FLG_CAP = 5;
  localparam logic [7:0] FLG_IMPL = 8'h2F;
  localparam logic [3:0] MODE_FREE = 4'd0;
  localparam logic [3:0] MODE_TOP_CMPA = 4'd4;
  localparam logic [3:0] MODE_TOP_ICR = 4'd12;

  typedef struct packed {
    logic load;
    logic advance;
    logic clear;
    logic setOvf;
    logic [NCH-1:0] setCmp;
    logic setCap;
  } strobe_t;
endpackage

// File: rtl/ctc_timer16_ctrl.sv
module ctc_timer16_ctrl
  import ctc_timer16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrHold,
  input  logic             tick,
  input  logic             loadEn,
  input  logic [7:0]       ctlA,
  input  logic [7:0]       ctlB,
  input  logic [WIDTH-1:0] cmpA,
  input  logic [WIDTH-1:0] cmpB,
  input  logic [WIDTH-1:0] cmpC,
  input  logic [WIDTH-1:0] topIcr,
  input  logic [WIDTH-1:0] count,
  output strobe_t          st
);
  localparam logic [WIDTH-1:0] MAXV = '1;

  logic [3:0] mode;
  logic blockNext;
  logic live;
  logic atMax;
  logic topHitA;
  logic topHitI;
  logic [WIDTH-1:0] cmpVec [NCH];
  logic [NCH-1:0] eqCmp;

  assign mode = {ctlB[4:3], ctlA[1:0]};
  assign cmpVec[0] = cmpA;
  assign cmpVec[1] = cmpB;
  assign cmpVec[2] = cmpC;

  for (genvar g = 0; g < NCH; g++) begin : gMatch
    assign eqCmp[g] = (count == cmpVec[g]);
  end

  assign live = !blockNext;
  assign atMax = (count == MAXV);
  assign topHitA = (mode == MODE_TOP_CMPA) && live && eqCmp[0];
  assign topHitI = (mode == MODE_TOP_ICR) && live && (count == topIcr);

  always_comb begin
    st = '0;
    if (!pwrHold) begin
      if (loadEn) begin
        st.load = 1'b1;
      end else if (tick) begin
        st.advance = 1'b1;
        st.setCmp = live ? eqCmp : '0;
        st.setCap = topHitI;
        st.setOvf = atMax;
        st.clear = atMax || topHitA || topHitI;
      end
    end
  end

  // One-tick match suppression after a software load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blockNext <= 1'b0;
    else if (pwrHold) blockNext <= 1'b0;
    else if (loadEn) blockNext <= 1'b1;
    else if (tick) blockNext <= 1'b0;
  end
endmodule

// File: rtl/ctc_timer16_dpath.sv
module ctc_timer16_dpath
  import ctc_timer16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrHold,
  input  strobe_t          st,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [7:0]       intMask,
  input  logic             flagClrEn,
  input  logic [7:0]       flagClrVal,
  output logic [WIDTH-1:0] count,
  output logic [7:0]       flags,
  output logic [7:0]       irqVec
);
  logic [7:0] setVec;
  logic [7:0] kept;

  always_comb begin
    setVec = '0;
    setVec[FLG_OVF] = st.setOvf;
    setVec[FLG_CAP] = st.setCap;
    for (int i = 0; i < NCH; i++) setVec[FLG_CMP0 + i] = st.setCmp[i];
  end

  assign kept = flagClrEn ? (flags & ~flagClrVal) : flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      flags <= '0;
    end else if (pwrHold) begin
      count <= '0;
      flags <= '0;
    end else begin
      if (st.load) count <= loadVal;
      else if (st.advance) count <= st.clear ? '0 : count + 1'b1;
      flags <= (kept | setVec) & FLG_IMPL;
    end
  end

  assign irqVec = pwrHold ? 8'h00 : (flags & intMask);
endmodule

// File: rtl/ctc_timer16.sv
module ctc_timer16
  import ctc_timer16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrHold,
  input  logic             tick,
  input  logic [7:0]       ctlA,
  input  logic [7:0]       ctlB,
  input  logic [WIDTH-1:0] cmpA,
  input  logic [WIDTH-1:0] cmpB,
  input  logic [WIDTH-1:0] cmpC,
  input  logic [WIDTH-1:0] topIcr,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [7:0]       intMask,
  input  logic             flagClrEn,
  input  logic [7:0]       flagClrVal,
  output logic [WIDTH-1:0] count,
  output logic [7:0]       flags,
  output logic             irqOvf,
  output logic             irqCmpA,
  output logic             irqCmpB,
  output logic             irqCmpC,
  output logic             irqCapt
);
  strobe_t st;
  logic [7:0] irqVec;

  ctc_timer16_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrHold(pwrHold), .tick(tick), .loadEn(loadEn),
    .ctlA(ctlA), .ctlB(ctlB), .cmpA(cmpA), .cmpB(cmpB), .cmpC(cmpC),
    .topIcr(topIcr), .count(count), .st(st)
  );

  ctc_timer16_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .pwrHold(pwrHold), .st(st), .loadVal(loadVal),
    .intMask(intMask), .flagClrEn(flagClrEn), .flagClrVal(flagClrVal),
    .count(count), .flags(flags), .irqVec(irqVec)
  );

  assign irqOvf  = irqVec[FLG_OVF];
  assign irqCmpA = irqVec[FLG_CMP0];
  assign irqCmpB = irqVec[FLG_CMP0 + 1];
  assign irqCmpC = irqVec[FLG_CMP0 + 2];
  assign irqCapt = irqVec[FLG_CAP];
endmodule

// File: rtl/ctc_timer16_chk.sv
module ctc_timer16_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrHold,
  input logic             tick,
  input logic             loadEn,
  input logic [WIDTH-1:0] loadVal,
  input logic [7:0]       intMask,
  input logic [WIDTH-1:0] count,
  input logic [7:0]       flags,
  input logic             irqOvf,
  input logic             irqCmpA,
  input logic             irqCmpB,
  input logic             irqCmpC,
  input logic             irqCapt
);
  localparam logic [WIDTH-1:0] MAXV = '1;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !loadEn && !pwrHold) |=> $stable(count)); // R2
  AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !loadEn && !pwrHold && count == MAXV) |=> (count == '0 && flags[0])); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && !pwrHold) |=> (count == $past(loadVal))); // R7
  AST_NO_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loadEn) && !$past(pwrHold) && tick && !loadEn && !pwrHold)
      |=> (!$rose(flags[1]) && !$rose(flags[2]) && !$rose(flags[3]) && !$rose(flags[5]))); // R7
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irqCmpB |-> (intMask[2] && flags[2]))); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwrHold |-> !(irqOvf || irqCmpA || irqCmpB || irqCmpC || irqCapt)); // R10
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwrHold |=> (count == '0 && flags == 8'h00)); // R10
endmodule

bind ctc_timer16 ctc_timer16_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrHold(pwrHold), .tick(tick), .loadEn(loadEn),
  .loadVal(loadVal), .intMask(intMask), .count(count), .flags(flags),
  .irqOvf(irqOvf), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqCmpC(irqCmpC),
  .irqCapt(irqCapt)
);

// File: tb/test_ctc_timer16.sv
module test_ctc_timer16;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrHold = 1'b0, tick = 1'b0, loadEn = 1'b0, flagClrEn = 1'b0;
  logic [7:0] ctlA = '0, ctlB = '0, intMask = '0, flagClrVal = '0;
  logic [W-1:0] cmpA = '0, cmpB = '0, cmpC = '0, topIcr = '0, loadVal = '0;
  logic [W-1:0] count;
  logic [7:0] flags;
  logic irqOvf, irqCmpA, irqCmpB, irqCmpC, irqCapt;

  int checks = 0, failures = 0;
  bit done = 0;
  bit compareOn = 0;
  string curReq = "R12";
  int maxSeen;

  always #10 clk = ~clk;

  ctc_timer16 #(.WIDTH(W)) i_ctc_timer16 (
    .clk(clk), .rst_n(rst_n), .pwrHold(pwrHold), .tick(tick), .ctlA(ctlA),
    .ctlB(ctlB), .cmpA(cmpA), .cmpB(cmpB), .cmpC(cmpC), .topIcr(topIcr),
    .loadEn(loadEn), .loadVal(loadVal), .intMask(intMask),
    .flagClrEn(flagClrEn), .flagClrVal(flagClrVal), .count(count),
    .flags(flags), .irqOvf(irqOvf), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB),
    .irqCmpC(irqCmpC), .irqCapt(irqCapt)
  );

  // Behavioural reference
  int mCnt = 0, mFlg = 0, mBlk = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt <= 0; mFlg <= 0; mBlk <= 0;
    end else if (pwrHold) begin
      mCnt <= 0; mFlg <= 0; mBlk <= 0;
    end else begin
      int md, sets, nxt, keep;
      bit top;
      md = {ctlB[4:3], ctlA[1:0]};
      sets = 0;
      nxt = mCnt;
      if (loadEn) begin
        nxt = loadVal;
        mBlk <= 1;
      end else if (tick) begin
        top = 0;
        if (mBlk == 0) begin
          if (mCnt == cmpA) sets |= 2;
          if (mCnt == cmpB) sets |= 4;
          if (mCnt == cmpC) sets |= 8;
          if (md == 4 && mCnt == cmpA) top = 1;
          if (md == 12 && mCnt == topIcr) begin top = 1; sets |= 32; end
        end
        if (mCnt == MAXV) begin sets |= 1; nxt = 0; end
        else if (top) nxt = 0;
        else nxt = mCnt + 1;
        mBlk <= 0;
      end
      keep = flagClrEn ? (mFlg & ~int'(flagClrVal)) : mFlg;
      mCnt <= nxt;
      mFlg <= keep | sets;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && compareOn && !done) begin
      int irqE;
      irqE = pwrHold ? 0 : (mFlg & intMask);
      chk({curReq, " count"}, count, mCnt);
      chk({curReq, " flags"}, flags, mFlg);
      chk({curReq, " irq"}, {irqCapt, 1'b0, irqCmpC, irqCmpB, irqCmpA, irqOvf},
          irqE & 8'h2F);
      if (int'(count) > maxSeen) maxSeen = count;
    end
  end

  task automatic drv(bit t, bit ld, int lv, bit ce, int cv);
    tick = t; loadEn = ld; loadVal = W'(lv); flagClrEn = ce; flagClrVal = 8'(cv);
    @(posedge clk); #2;
    tick = 0; loadEn = 0; flagClrEn = 0;
  endtask

  task automatic run(int n, bit alt);
    for (int i = 0; i < n; i++) drv(alt ? (i % 2 == 0) : 1'b1, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 count in reset", count, 0);
    chk("R12 flags in reset", flags, 0);
    @(posedge clk); #2;
    rst_n = 1;
    compareOn = 1;

    // Free-running with compares and overflow
    curReq = "R3/R6";
    cmpA = 10; cmpB = 20; cmpC = 30; intMask = 8'h2F;
    run(300, 0);
    @(negedge clk);
    chk("R3 overflow flag", flags[0], 1);
    chk("R6 compare C flag", flags[3], 1);
    curReq = "R8";
    intMask = 8'h00;
    @(negedge clk);
    chk("R8 masked irq low", irqOvf, 0);
    chk("R8 flag kept when masked", flags[0], 1);
    @(posedge clk); #2;

    // Write-one-to-clear
    curReq = "R9";
    drv(0, 0, 0, 1, 8'h00);
    @(negedge clk);
    chk("R9 zero write keeps", flags, 8'h0F);
    drv(0, 0, 0, 1, 8'h2F);
    @(negedge clk);
    chk("R9 clear all", flags, 0);
    cmpA = 51;
    drv(0, 1, 49, 0, 0);
    drv(1, 0, 0, 0, 0);
    drv(1, 0, 0, 0, 0);
    drv(1, 0, 0, 1, 8'h02);
    @(negedge clk);
    chk("R9 set wins over clear", flags[1], 1);

    // Clear at compare A
    curReq = "R4";
    ctlB = 8'h08; cmpA = 40;
    drv(0, 0, 0, 1, 8'hFF);
    drv(0, 1, 0, 0, 0);
    maxSeen = 0;
    run(200, 1);
    chk("R4 count capped at cmpA", maxSeen, 40);
    chk("R4 compare A flag", flags[1], 1);

    // Clear at capture register
    curReq = "R5";
    ctlB = 8'h18; topIcr = 60;
    drv(0, 0, 0, 1, 8'hFF);
    drv(0, 1, 0, 0, 0);
    maxSeen = 0;
    run(200, 0);
    chk("R5 count capped at topIcr", maxSeen, 60);
    chk("R5 capture flag", flags[5], 1);

    // Unlisted mode behaves as free running
    curReq = "R1";
    ctlA = 8'h01; ctlB = 8'h08;
    drv(0, 1, 0, 0, 0);
    run(100, 0);
    @(negedge clk);
    chk("R1 mode 5 runs past cmpA", count, 100);

    // Load priority and match suppression
    curReq = "R7";
    ctlA = 8'h00; ctlB = 8'h08; cmpA = 40;
    drv(0, 0, 0, 1, 8'hFF);
    drv(1, 1, 40, 0, 0);
    @(negedge clk);
    chk("R7 load beats tick", count, 40);
    drv(1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R7 no clear after load", count, 41);
    chk("R7 no compare flag after load", flags[1], 0);

    // Power hold
    curReq = "R10";
    ctlB = 8'h00; intMask = 8'h2F;
    drv(0, 1, MAXV, 0, 0);
    drv(1, 0, 0, 0, 0);
    pwrHold = 1;
    @(negedge clk);
    chk("R10 irq low at once", irqOvf, 0);
    tick = 1;
    repeat (3) @(posedge clk);
    #2;
    tick = 0;
    @(negedge clk);
    chk("R10 count held", count, 0);
    chk("R10 flags held", flags, 0);
    pwrHold = 0;
    @(posedge clk); #2;

    // Random mix
    curReq = "R2/R6/R7/R9";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      if (i % 400 == 0) begin
        sel = $urandom_range(0, 3);
        ctlA = (sel == 3) ? 8'h01 : 8'h00;
        ctlB = (sel == 0) ? 8'h00 : (sel == 2 ? 8'h18 : 8'h08);
        cmpA = W'($urandom_range(20, MAXV)); cmpB = W'($urandom);
        cmpC = W'($urandom); topIcr = W'($urandom_range(20, MAXV));
        intMask = 8'($urandom);
      end
      pwrHold = ($urandom_range(0, 299) == 0);
      drv($urandom_range(0, 3) != 0, $urandom_range(0, 49) == 0, $urandom,
          $urandom_range(0, 9) == 0, $urandom);
      pwrHold = 0;
    end
    @(negedge clk);
    chk("R11 unused flag bits zero", flags & 8'hD0, 0);

    compareOn = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule